// File: doc/BRIEF.md
# Time-Shared Two-Read One-Write Register File

This block is a small register file that offers two read ports and one write port to its user while the storage behind it can do only one kind of access at a time: either a pair of independent reads or a single write. Each access cycle of the register file is split into two halves. The first half serves both reads. The second half commits the write that was requested at the start of the cycle. The time-shared array therefore behaves, from the outside, like a 2R1W file with a one-cycle write commit.

The block runs on a clock at twice the access rate. Each edge of `clk_i` is one phase. An internal phase register alternates between a read phase and a write phase and is shown on `phase_o`. A user drives addresses, write data and write enable before a read-phase edge. Read data appears after that edge and stays constant for the full access cycle. The write lands on the following write-phase edge, so a read in the same cycle at the same address still sees the earlier contents.

Top module: `rf_2r1w_phased`

## Requirements
- R1: While `rst_ni` is low and after its release, `phase_o` is 0 (read phase), both read data outputs are 0, and every entry holds 0.
- R2: `phase_o` toggles on every rising `clk_i` edge. An edge taken while `phase_o` is 0 is a read edge, and an edge taken while it is 1 is a write edge. One access cycle is a read edge followed by a write edge.
- R3: At a read edge, `rd_data_a_o` and `rd_data_b_o` load the entries addressed by `rd_addr_a_i` and `rd_addr_b_i`. The two ports are independent and may address the same entry.
- R4: `wr_en_i`, `wr_addr_i` and `wr_data_i` are sampled at the read edge. When `wr_en_i` was 1, the entry is updated at the following write edge. The storage is never read and written in the same phase.
- R5: A read at the same address as the write of the same cycle returns the value held before that write. A read in the next cycle returns the written value.
- R6: Both read data outputs hold their value from one read edge to the next, across the write edge.
- R7: Values on any input that are present only at a write edge are ignored. This includes a write enable raised only during the write phase.
- R8: When `wr_en_i` is 0 at a read edge, no entry changes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, two edges per access cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_o | output | 1 | Current phase: 0 read, 1 write |
| rd_addr_a_i | input | $clog2(DEPTH) | Read port A address |
| rd_data_a_o | output | WIDTH | Read port A data |
| rd_addr_b_i | input | $clog2(DEPTH) | Read port B address |
| rd_data_b_o | output | WIDTH | Read port B data |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | $clog2(DEPTH) | Write address |
| wr_data_i | input | WIDTH | Write data |

## Verification
The assertions check four properties on every edge: reads and writes never share a phase, writes occur only in the write phase, the read outputs do not move across a write edge, and a committed write leaves the addressed entry holding the captured data. The bench scenarios are needed to show the rest against a reference model. These are the old-value result of same-address collisions, new-value visibility one cycle later, both ports reading one entry, the rejection of write-phase-only stimulus, and the absence of any change when the write is disabled.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    PH_RD = 1'b0,
    PH_WR = 1'b1
  } phase_e;
endpackage

// File: rtl/rf_phase_ctrl.sv
module rf_phase_ctrl
  import rf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_RD;
    else         phase_q <= (phase_q == PH_RD) ? PH_WR : PH_RD;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/rf_wr_stage.sv
module rf_wr_stage #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,     // read edge: capture request
  input  logic          commit_i,  // write edge: allow commit
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          strobe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_i) begin
      pend_q <= wr_en_i;
      addr_q <= wr_addr_i;
      data_q <= wr_data_i;
    end
  end

  assign strobe_o = pend_q & commit_i;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
endmodule

// File: rtl/rf_array.sv
module rf_array #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_a_i,
  input  logic [AW-1:0] rd_addr_b_i,
  output logic [DW-1:0] rd_data_a_o,
  output logic [DW-1:0] rd_data_b_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rda_q, rdb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rda_q <= '0;
      rdb_q <= '0;
    end else if (rd_en_i) begin
      rda_q <= mem_q[rd_addr_a_i];
      rdb_q <= mem_q[rd_addr_b_i];
    end
  end

  assign rd_data_a_o = rda_q;
  assign rd_data_b_o = rdb_q;

  // R4
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_en_i, wr_en_i}));

  // R4
  commit_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rda_q) && $stable(rdb_q));
endmodule

// File: rtl/rf_2r1w_phased.sv
module rf_2r1w_phased
  import rf_pkg::*;
#(
  parameter int  DEPTH = 32,
  parameter int  WIDTH = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             phase_o,
  input  logic [AW-1:0]    rd_addr_a_i,
  output logic [WIDTH-1:0] rd_data_a_o,
  input  logic [AW-1:0]    rd_addr_b_i,
  output logic [WIDTH-1:0] rd_data_b_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i
);
  phase_e           phase;
  logic             rd_phase, wr_phase;
  logic             wr_strobe;
  logic [AW-1:0]    wr_addr;
  logic [WIDTH-1:0] wr_data;

  rf_phase_ctrl u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  assign rd_phase = (phase == PH_RD);
  assign wr_phase = (phase == PH_WR);
  assign phase_o  = phase;

  rf_wr_stage #(.AW(AW), .DW(WIDTH)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (rd_phase),
    .commit_i (wr_phase),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .strobe_o (wr_strobe),
    .addr_o   (wr_addr),
    .data_o   (wr_data)
  );

  rf_array #(.DEPTH(DEPTH), .DW(WIDTH)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_phase),
    .rd_addr_a_i(rd_addr_a_i),
    .rd_addr_b_i(rd_addr_b_i),
    .rd_data_a_o(rd_data_a_o),
    .rd_data_b_o(rd_data_b_o),
    .wr_en_i    (wr_strobe),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data)
  );

  // R4
  wr_in_wr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe |-> phase == PH_WR);

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WR) |=> $stable(rd_data_a_o) && $stable(rd_data_b_o));
endmodule

// File: tb/rf_2r1w_phased_tb.sv
module rf_2r1w_phased_tb;
  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             phase;
  logic [AW-1:0]    ra, rb, wa;
  logic [WIDTH-1:0] rda, rdb, wd;
  logic             we;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [WIDTH-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  rf_2r1w_phased #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_o(phase),
    .rd_addr_a_i(ra), .rd_data_a_o(rda),
    .rd_addr_b_i(rb), .rd_data_b_o(rdb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd)
  );

  function automatic logic [WIDTH-1:0] exp_rd(input logic [AW-1:0] a);
    return ref_mem[a];
  endfunction

  task automatic chk(input string req, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Called at a negedge with phase 0; returns at the negedge one cycle later.
  task automatic access(input logic [AW-1:0] a, input logic [AW-1:0] b,
                        input logic w_en, input logic [AW-1:0] w_a,
                        input logic [WIDTH-1:0] w_d, input string req);
    logic [WIDTH-1:0] ea, eb;
    chk("R2 read phase", {31'b0, phase}, 32'd0);
    ra = a; rb = b; we = w_en; wa = w_a; wd = w_d;
    ea = exp_rd(a); eb = exp_rd(b);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R3 port a"}, rda, ea);
    chk({req, " R3 port b"}, rdb, eb);
    chk("R2 write phase", {31'b0, phase}, 32'd1);
    // R7: write-phase-only stimulus must be ignored
    ra = AW'($urandom); rb = AW'($urandom);
    we = 1'b1; wa = AW'($urandom); wd = $urandom;
    @(posedge clk);
    if (w_en) ref_mem[w_a] = w_d;
    @(negedge clk);
    chk({req, " R6 hold a"}, rda, ea);
    chk({req, " R6 hold b"}, rdb, eb);
    we = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    ra = '0; rb = '0; wa = '0; wd = '0; we = 1'b0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 phase", {31'b0, phase}, 32'd0);
    chk("R1 rd a", rda, '0);
    chk("R1 rd b", rdb, '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 toggle", {31'b0, phase}, 32'd0);
    // R1: entries read as zero
    access(5'd0, 5'd31, 1'b0, '0, '0, "R1 zero");
    // R5: collision returns old, next cycle new
    access(5'd7, 5'd7, 1'b1, 5'd7, 32'hDEAD_BEEF, "R5 collide");
    access(5'd7, 5'd3, 1'b0, '0, '0, "R5 new");
    chk("R5 new value", rda, 32'hDEAD_BEEF);
    // boundary addresses
    access(5'd0, 5'd31, 1'b1, 5'd31, 32'hFFFF_0001, "R4 top");
    access(5'd31, 5'd31, 1'b1, 5'd0, 32'h1234_5678, "R3 same entry");
    access(5'd0, 5'd31, 1'b0, '0, '0, "R4 bottom");
    // R8: disabled write to entry 9 leaves it unchanged
    access(5'd9, 5'd9, 1'b0, 5'd9, 32'hAAAA_5555, "R8 setup");
    access(5'd9, 5'd0, 1'b0, '0, '0, "R8 check");
    chk("R8 unchanged", rda, 32'd0);
    // R7: request present only at write edge is checked via later reads
    access(5'd0, 5'd1, 1'b0, '0, '0, "R7 stim");
    for (int i = 0; i < DEPTH; i += 2)
      access(AW'(i), AW'(i + 1), 1'b0, '0, '0, "R7 scan");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa_r;
      wa_r = AW'($urandom);
      access(($urandom % 4 == 0) ? wa_r : AW'($urandom),
             ($urandom % 4 == 0) ? wa_r : AW'($urandom),
             1'($urandom), wa_r, $urandom, "rand R3 R4 R5");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule